// File: doc/BRIEF.md
# Radix-2 Delay-Feedback FFT Stage

This block is a single stage of a streaming radix-2 FFT built as a chain of delay-feedback stages. Complex samples arrive one per clock, marked by a valid strobe. The stage counts positions inside a group of `2*DELAY` samples. In the first half of a group, each incoming sample is parked in a feedback delay memory of `DELAY` words. In the second half, each arriving sample is paired with the parked sample `DELAY` positions earlier. Their sum leaves the stage at once, and their difference goes back into the same memory word. During the next group's first half, that stored difference is read out, in index order, while the new sample is written into the word it frees. Each memory cycle makes one read and one write at the same address, so the memory is a simple dual-port RAM. The butterfly adder is therefore only in use for half of each group.

A frame sync input, qualified by valid, forces the current sample to be group index 0. After a sync, the stage holds its output quiet until the first sum exists, so stale differences are never emitted. An optional complex twiddle multiply sits on the output path. The twiddle word is supplied alongside the input sample whose cycle produces that output. `DELAY` is `N / 2^(s+1)` for stage `s` of an `N`-point pipeline, and must be a power of two. The final stage of a pipeline is built with `USE_TWIDDLE = 0`.

Top module: `sdf_r2_stage`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` and `out_sync` are 0 and `out_re`/`out_im` are 0.
- R2: After a valid sample with `in_sync` = 1, the first `DELAY` valid samples of that group produce no output.
- R3: For group indices k = 0..DELAY-1, the sample at index k+DELAY produces an output equal to x[k] + x[k+DELAY]. The result is in `DATA_W+1` bit two's complement, before the twiddle.
- R4: The difference x[k] - x[k+DELAY] is stored in the delay. It is emitted when the next group's sample at index k arrives, so differences come out in increasing k order.
- R5: The group index advances by one for each valid sample, modulo 2*DELAY. A valid sample with `in_sync` = 1 takes index 0. `in_sync` has no effect while `in_valid` is 0.
- R6: `out_valid` is asserted exactly two clock cycles after each input sample that produces an output. With a continuous stream after a sync, the first output appears DELAY+2 cycles after the sync sample.
- R7: With `USE_TWIDDLE` = 1, the output equals (y * w) with the real and imaginary parts each arithmetically shifted right by TW_W-2 and kept to their low DATA_W+1 bits. Here y is the butterfly result and w is the twiddle given with the producing input sample. The value 1.0 is 2^(TW_W-2).
- R8: `out_sync` is 1 together with the first sum of a group that began with a sync, and at no other time.
- R9: Full-scale inputs (-2^(DATA_W-1) and 2^(DATA_W-1)-1) give exact sums and differences with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_sync | input | 1 | Marks a valid sample as group index 0 |
| in_re | input | DATA_W | Input real part, signed |
| in_im | input | DATA_W | Input imaginary part, signed |
| tw_re | input | TW_W | Twiddle real part, signed, 1.0 = 2^(TW_W-2) |
| tw_im | input | TW_W | Twiddle imaginary part, signed |
| out_valid | output | 1 | Output sample strobe |
| out_sync | output | 1 | First sum of a synced group |
| out_re | output | DATA_W+1 | Output real part, signed |
| out_im | output | DATA_W+1 | Output imaginary part, signed |

## Verification
A continuous ramp with a unity twiddle pins down the exact output latency and the silence of the first fill half. Full-scale groups show that the one-bit growth absorbs every sum and difference. Random data with random valid gaps and random twiddles separates correct sum/difference ordering from any swap of halves or address error. Gaps also show that the index advances only on valid samples. Two cases separate true re-alignment from stray sync pulses: a sync pulse without valid, and a sync arriving part-way through a group. A pure -j twiddle checks the real and imaginary cross terms and their signs.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

  typedef enum logic {
    PH_FILL    = 1'b0,
    PH_COMPUTE = 1'b1
  } sdf_phase_e;

  // Real part of a complex product, full precision.
  function automatic longint cmul_re(input longint ar, input longint ai,
                                     input longint br, input longint bi);
    return ar * br - ai * bi;
  endfunction

  // Imaginary part of a complex product, full precision.
  function automatic longint cmul_im(input longint ar, input longint ai,
                                     input longint br, input longint bi);
    return ar * bi + ai * br;
  endfunction

  // Arithmetic right shift used to drop twiddle fraction bits.
  function automatic longint ashr(input longint v, input int sh);
    return v >>> sh;
  endfunction

endpackage

// File: rtl/sdf_phase_ctrl.sv
module sdf_phase_ctrl #(
  parameter int DELAY  = 8,
  parameter int CNT_W  = $clog2(DELAY) + 1,
  parameter int ADDR_W = (DELAY > 1) ? $clog2(DELAY) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_sync,
  output logic [CNT_W-1:0]         grp_idx,
  output logic [ADDR_W-1:0]        addr,
  output sdf_pkg::sdf_phase_e      phase,
  output logic                     emit,
  output logic                     sync_hit
);
  logic [CNT_W-1:0] cnt_q;
  logic             primed_q;
  logic             flag_q;
  logic             primed_eff;
  logic             flag_eff;
  logic             first_sum;

  // Sync forces index 0 for the sample that carries it.
  assign grp_idx = in_sync ? '0 : cnt_q;
  assign phase   = sdf_pkg::sdf_phase_e'(grp_idx[CNT_W-1]);

  generate
    if (DELAY > 1) begin : g_addr
      assign addr = grp_idx[ADDR_W-1:0];
    end else begin : g_addr_one
      assign addr = '0;
    end
  endgenerate

  assign first_sum  = (phase == sdf_pkg::PH_COMPUTE) && (addr == '0);
  assign primed_eff = in_sync ? 1'b0 : primed_q;
  assign flag_eff   = in_sync | flag_q;
  assign emit       = in_valid && ((phase == sdf_pkg::PH_COMPUTE) || primed_eff);
  assign sync_hit   = in_valid && first_sum && flag_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
      flag_q   <= 1'b0;
    end else if (in_valid) begin
      cnt_q    <= grp_idx + CNT_W'(1);
      primed_q <= (phase == sdf_pkg::PH_COMPUTE) ? 1'b1 : primed_eff;
      if (in_sync)        flag_q <= 1'b1;
      else if (first_sum) flag_q <= 1'b0;
    end
  end

endmodule

// File: rtl/sdf_delay_ram.sv
module sdf_delay_ram #(
  parameter int WORD_W = 17,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic signed [WORD_W-1:0] wr_re,
  input  logic signed [WORD_W-1:0] wr_im,
  output logic signed [WORD_W-1:0] rd_re,
  output logic signed [WORD_W-1:0] rd_im
);
  localparam int PAIR_W = 2 * WORD_W;

  logic [PAIR_W-1:0] mem [DEPTH];
  logic [PAIR_W-1:0] rd_word;

  // Old word is read and new word written at the same address each cycle.
  assign rd_word = mem[addr];
  assign rd_re   = rd_word[PAIR_W-1:WORD_W];
  assign rd_im   = rd_word[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= {wr_re, wr_im};
  end

endmodule

// File: rtl/sdf_twiddle_stage.sv
module sdf_twiddle_stage #(
  parameter int OUT_W       = 17,
  parameter int TW_W        = 16,
  parameter int USE_TWIDDLE = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     y_valid,
  input  logic                     y_sync,
  input  logic signed [OUT_W-1:0]  y_re,
  input  logic signed [OUT_W-1:0]  y_im,
  input  logic signed [TW_W-1:0]   w_re,
  input  logic signed [TW_W-1:0]   w_im,
  output logic                     z_valid,
  output logic                     z_sync,
  output logic signed [OUT_W-1:0]  z_re,
  output logic signed [OUT_W-1:0]  z_im
);
  localparam int SHIFT = TW_W - 2;

  logic signed [OUT_W-1:0] rot_re;
  logic signed [OUT_W-1:0] rot_im;

  generate
    if (USE_TWIDDLE != 0) begin : g_rot
      always_comb begin
        rot_re = OUT_W'(sdf_pkg::ashr(sdf_pkg::cmul_re(longint'(y_re), longint'(y_im),
                                                       longint'(w_re), longint'(w_im)), SHIFT));
        rot_im = OUT_W'(sdf_pkg::ashr(sdf_pkg::cmul_im(longint'(y_re), longint'(y_im),
                                                       longint'(w_re), longint'(w_im)), SHIFT));
      end
    end else begin : g_pass
      logic unused_tw;
      assign unused_tw = ^{w_re, w_im};
      assign rot_re    = y_re;
      assign rot_im    = y_im;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_valid <= 1'b0;
      z_sync  <= 1'b0;
      z_re    <= '0;
      z_im    <= '0;
    end else begin
      z_valid <= y_valid;
      z_sync  <= y_sync;
      if (y_valid) begin
        z_re <= rot_re;
        z_im <= rot_im;
      end
    end
  end

endmodule

// File: rtl/sdf_r2_stage.sv
module sdf_r2_stage #(
  parameter int DATA_W      = 16,
  parameter int TW_W        = 16,
  parameter int DELAY       = 8,
  parameter int USE_TWIDDLE = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_sync,
  input  logic signed [DATA_W-1:0] in_re,
  input  logic signed [DATA_W-1:0] in_im,
  input  logic signed [TW_W-1:0]   tw_re,
  input  logic signed [TW_W-1:0]   tw_im,
  output logic                     out_valid,
  output logic                     out_sync,
  output logic signed [DATA_W:0]   out_re,
  output logic signed [DATA_W:0]   out_im
);
  localparam int OUT_W  = DATA_W + 1;
  localparam int CNT_W  = $clog2(DELAY) + 1;
  localparam int ADDR_W = (DELAY > 1) ? $clog2(DELAY) : 1;

  // Named internal events, also observed by the bound checker.
  logic [CNT_W-1:0]          grp_idx;
  logic [ADDR_W-1:0]         mem_addr;
  sdf_pkg::sdf_phase_e       phase;
  logic                      emit;
  logic                      sync_hit;
  logic                      mem_we;

  logic signed [OUT_W-1:0]   x_re, x_im;
  logic signed [OUT_W-1:0]   rd_re, rd_im;
  logic signed [OUT_W-1:0]   bf_sum_re, bf_sum_im;
  logic signed [OUT_W-1:0]   bf_dif_re, bf_dif_im;
  logic signed [OUT_W-1:0]   wr_re, wr_im;
  logic signed [OUT_W-1:0]   y_re, y_im;

  logic                      s1_valid, s1_sync;
  logic signed [OUT_W-1:0]   s1_re, s1_im;
  logic signed [TW_W-1:0]    s1_wr, s1_wi;

  sdf_phase_ctrl #(
    .DELAY (DELAY),
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_sync (in_sync),
    .grp_idx (grp_idx),
    .addr    (mem_addr),
    .phase   (phase),
    .emit    (emit),
    .sync_hit(sync_hit)
  );

  assign x_re = OUT_W'(in_re);
  assign x_im = OUT_W'(in_im);

  // Butterfly: parked sample against the arriving one.
  assign bf_sum_re = rd_re + x_re;
  assign bf_sum_im = rd_im + x_im;
  assign bf_dif_re = rd_re - x_re;
  assign bf_dif_im = rd_im - x_im;

  // Fill half parks the input and emits an old difference;
  // compute half emits the sum and parks the difference.
  assign mem_we = in_valid;
  assign wr_re  = (phase == sdf_pkg::PH_COMPUTE) ? bf_dif_re : x_re;
  assign wr_im  = (phase == sdf_pkg::PH_COMPUTE) ? bf_dif_im : x_im;
  assign y_re   = (phase == sdf_pkg::PH_COMPUTE) ? bf_sum_re : rd_re;
  assign y_im   = (phase == sdf_pkg::PH_COMPUTE) ? bf_sum_im : rd_im;

  sdf_delay_ram #(
    .WORD_W(OUT_W),
    .DEPTH (DELAY),
    .ADDR_W(ADDR_W)
  ) u_ram (
    .clk  (clk),
    .we   (mem_we),
    .addr (mem_addr),
    .wr_re(wr_re),
    .wr_im(wr_im),
    .rd_re(rd_re),
    .rd_im(rd_im)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_sync  <= 1'b0;
      s1_re    <= '0;
      s1_im    <= '0;
      s1_wr    <= '0;
      s1_wi    <= '0;
    end else begin
      s1_valid <= emit;
      s1_sync  <= sync_hit;
      if (emit) begin
        s1_re <= y_re;
        s1_im <= y_im;
        s1_wr <= tw_re;
        s1_wi <= tw_im;
      end
    end
  end

  sdf_twiddle_stage #(
    .OUT_W      (OUT_W),
    .TW_W       (TW_W),
    .USE_TWIDDLE(USE_TWIDDLE)
  ) u_tw (
    .clk    (clk),
    .rst_n  (rst_n),
    .y_valid(s1_valid),
    .y_sync (s1_sync),
    .y_re   (s1_re),
    .y_im   (s1_im),
    .w_re   (s1_wr),
    .w_im   (s1_wi),
    .z_valid(out_valid),
    .z_sync (out_sync),
    .z_re   (out_re),
    .z_im   (out_im)
  );

endmodule

// File: rtl/sdf_r2_stage_chk.sv
module sdf_r2_stage_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sync,
  input logic             out_valid,
  input logic             out_sync,
  input logic [CNT_W-1:0] grp_idx
);

  // R6: every output traces back to a sample two cycles earlier.
  a_r6_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  // R2: a sync sample starts a fill half and yields nothing.
  a_r2_quiet_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sync) |=> ##1 !out_valid);

  // R5: index steps by one per valid sample.
  a_r5_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (in_sync || grp_idx == CNT_W'($past(grp_idx) + 1)));

  // R5: index holds while idle and sync without valid does nothing.
  a_r5_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !in_sync) |=> (in_sync || $stable(grp_idx)));

  // R8: output sync only rides on a valid output.
  a_r8_sync_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_sync |-> out_valid);

  // R8: output sync is a single-cycle mark.
  a_r8_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_sync |=> !out_sync);

endmodule

bind sdf_r2_stage sdf_r2_stage_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_sync  (in_sync),
  .out_valid(out_valid),
  .out_sync (out_sync),
  .grp_idx  (grp_idx)
);

// File: tb/tb_sdf_r2_stage.sv
module tb_sdf_r2_stage;
  localparam int DATA_W = 16;
  localparam int TW_W   = 16;
  localparam int DELAY  = 8;
  localparam int OUT_W  = DATA_W + 1;
  localparam int SH     = TW_W - 2;
  localparam longint ONE = 64'sd1 <<< SH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sync = 1'b0;
  logic signed [DATA_W-1:0] in_re = '0, in_im = '0;
  logic signed [TW_W-1:0] tw_re = '0, tw_im = '0;
  logic out_valid, out_sync;
  logic signed [OUT_W-1:0] out_re, out_im;

  always #5ns clk = ~clk;

  sdf_r2_stage #(.DATA_W(DATA_W), .TW_W(TW_W), .DELAY(DELAY), .USE_TWIDDLE(1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
    .in_re(in_re), .in_im(in_im), .tw_re(tw_re), .tw_im(tw_im),
    .out_valid(out_valid), .out_sync(out_sync), .out_re(out_re), .out_im(out_im));

  int checks = 0, fails = 0;
  int pcnt = 0;
  bit done = 0;
  int kind_sel = 0;
  bit got_first = 0;
  int first_at = 0;

  longint q_re[$], q_im[$];
  bit q_sync[$];
  int q_kind[$];

  longint cur_re[2*DELAY], cur_im[2*DELAY];
  longint dif_re[DELAY], dif_im[DELAY];
  int m_j = 0;
  bit m_primed = 0, m_gsync = 0;

  always @(posedge clk) pcnt <= pcnt + 1;

  function automatic string tagof(int k);
    case (k)
      2: return "R2";
      4: return "R4";
      5: return "R5";
      7: return "R7";
      9: return "R9";
      default: return "R3";
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic longint wrap_out(longint v);
    longint m;
    m = v & ((64'sd1 <<< OUT_W) - 1);
    if (m >= (64'sd1 <<< (OUT_W - 1))) m = m - (64'sd1 <<< OUT_W);
    return m;
  endfunction

  // Rotation per R7, floor of product over 2^SH then low OUT_W bits.
  function automatic longint rot_r(longint yr, longint yi, longint wr, longint wi);
    longint p = (yr * wr) + (-(yi * wi));
    return wrap_out(p >>> SH);
  endfunction
  function automatic longint rot_i(longint yr, longint yi, longint wr, longint wi);
    longint p = (yi * wr) + (yr * wi);
    return wrap_out(p >>> SH);
  endfunction

  task automatic push(longint yr, longint yi, longint wr, longint wi, bit s, int natural);
    q_re.push_back(rot_r(yr, yi, wr, wi));
    q_im.push_back(rot_i(yr, yi, wr, wi));
    q_sync.push_back(s);
    q_kind.push_back(kind_sel != 0 ? kind_sel : natural);
  endtask

  // Reference model of the stage stream (R2..R5, R8).
  task automatic model(bit s, longint xr, longint xi, longint wr, longint wi);
    int k;
    int m;
    if (s) begin
      m_j = 0; m_primed = 0; m_gsync = 1;
    end
    k = m_j;
    if (k < DELAY) begin
      if (m_primed) push(dif_re[k], dif_im[k], wr, wi, 1'b0, 4);
      cur_re[k] = xr; cur_im[k] = xi;
    end else begin
      m = k - DELAY;
      dif_re[m] = cur_re[m] - xr;
      dif_im[m] = cur_im[m] - xi;
      push(cur_re[m] + xr, cur_im[m] + xi, wr, wi, (m == 0) && m_gsync, 3);
      if (m == 0) m_gsync = 0;
      m_primed = 1;
    end
    m_j = (m_j + 1) % (2 * DELAY);
  endtask

  task automatic drive(bit v, bit s, longint xr, longint xi, longint wr, longint wi);
    @(negedge clk);
    in_valid = v; in_sync = s;
    in_re = xr[DATA_W-1:0]; in_im = xi[DATA_W-1:0];
    tw_re = wr[TW_W-1:0];   tw_im = wi[TW_W-1:0];
    if (v) model(s, xr, xi, wr, wi);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 0, 0, ONE, 0);
  endtask

  function automatic longint rnd_data();
    return longint'($signed(16'($urandom)));
  endfunction

  function automatic longint rnd_tw();
    return longint'($urandom_range(0, 2 * 16384)) - 16384;
  endfunction

  // Output monitor: compare each output against the model queue.
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (!got_first) begin
        got_first = 1;
        first_at = pcnt;
      end
      if (q_re.size() == 0) begin
        check(1'b0, "R6", "unexpected output", 1, 0);
      end else begin
        string t;
        longint er, ei;
        bit es;
        er = q_re.pop_front(); ei = q_im.pop_front();
        es = q_sync.pop_front(); t = tagof(q_kind.pop_front());
        check(longint'(out_re) == er, t, "out_re", longint'(out_re), er);
        check(longint'(out_im) == ei, t, "out_im", longint'(out_im), ei);
        check(out_sync == es, "R8", "out_sync", longint'(out_sync), longint'(es));
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #2ms;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    int mark;
    void'($urandom(32'd2024));

    // R1: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
    check(out_sync == 1'b0, "R1", "out_sync in reset", longint'(out_sync), 0);
    check(out_re == '0 && out_im == '0, "R1", "data in reset", longint'(out_re), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);

    // R2/R6: continuous ramp, unity twiddle, exact first-output latency
    got_first = 0;
    @(negedge clk);
    mark = pcnt;
    in_valid = 1; in_sync = 1; in_re = 16'sd1; in_im = -16'sd1; tw_re = 16'(ONE); tw_im = '0;
    model(1'b1, 1, -1, ONE, 0);
    for (int i = 1; i < 4 * DELAY; i++) drive(1'b1, 1'b0, i + 1, -3 * i, ONE, 0);
    idle(6);
    check(got_first && (first_at - mark) >= DELAY + 2, "R2", "quiet fill half",
          first_at - mark, DELAY + 2);
    check(got_first && (first_at - mark) == DELAY + 2, "R6", "first output delay",
          first_at - mark, DELAY + 2);

    // R9: full-scale groups
    kind_sel = 9;
    for (int i = 0; i < 2 * DELAY; i++) drive(1'b1, i == 0, -32768, 32767, ONE, 0);
    for (int i = 0; i < DELAY; i++) drive(1'b1, 1'b0, 32767, -32768, ONE, 0);
    for (int i = 0; i < DELAY; i++) drive(1'b1, 1'b0, -32768, 32767, ONE, 0);
    for (int i = 0; i < 2 * DELAY; i++) drive(1'b1, 1'b0, 0, 0, ONE, 0);
    kind_sel = 0;
    idle(4);

    // R7: -j twiddle then random twiddles
    kind_sel = 7;
    for (int i = 0; i < 2 * DELAY; i++) drive(1'b1, i == 0, rnd_data(), rnd_data(), 0, -ONE);
    for (int i = 0; i < 4 * DELAY; i++) drive(1'b1, 1'b0, rnd_data(), rnd_data(), rnd_tw(), rnd_tw());
    kind_sel = 0;

    // R5: sync without valid is ignored; sync mid-group realigns
    kind_sel = 5;
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, rnd_data(), rnd_data(), ONE, 0);
    drive(1'b0, 1'b1, 0, 0, ONE, 0);
    drive(1'b0, 1'b1, 0, 0, ONE, 0);
    for (int i = 0; i < 2 * DELAY; i++) drive(1'b1, 1'b0, rnd_data(), rnd_data(), ONE, 0);
    drive(1'b1, 1'b1, rnd_data(), rnd_data(), ONE, 0);
    for (int i = 1; i < 3 * DELAY; i++) drive(1'b1, 1'b0, rnd_data(), rnd_data(), ONE, 0);
    kind_sel = 0;

    // R3/R4/R8: random data with gaps, frame syncs every four groups
    for (int g = 0; g < 12; g++) begin
      for (int i = 0; i < 2 * DELAY; i++) begin
        if ($urandom_range(0, 3) == 0) drive(1'b0, $urandom_range(0, 1) == 1, 0, 0, ONE, 0);
        drive(1'b1, (i == 0) && (g % 4 == 0), rnd_data(), rnd_data(), rnd_tw(), rnd_tw());
      end
    end

    idle(30);
    check(q_re.size() == 0, "R6", "outputs outstanding", q_re.size(), 0);
    finish_run();
  end

endmodule